// File: doc/BRIEF.md
# Fuse Array Burst Read Controller

This block sits between a simple register bus and a one-time-programmable fuse macro of 1024 bytes, organised as 32 rows of 32 bytes. Software sets two timing counts in a configuration register, then writes a control register with a byte address and the read-enable bit. The controller drives the row index on the fuse address bus and holds it for a programmable setup time. It then raises the read strobe for a programmable time and, on the last strobe cycle, latches the whole 256-bit row into eight data registers. A sticky done flag and an optional interrupt tell software that the row can be read.

The sequencer is a three-state machine. IDLE goes to SETUP on an accepted start. SETUP goes to STROBE after `adjust + 1` cycles. STROBE goes back to IDLE after `strobe + 4` cycles, and the row is captured on that final cycle. The program-enable and write-enable control bits are stored and read back, but they trigger nothing.

Top module: `fuse_read_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and `fuse_strobe` is 0.
- R2: Registers are addressed by byte offset: control at 0x0, configuration at 0x4, status at 0x8, and data word n at 0xC + 4n for n = 0..7. Configuration keeps bit 31 (interrupt enable), bits 23:20 (adjust count), bits 19:16 (strobe count), bits 15:12 and bits 11:0. Its other bits read 0.
- R3: Control keeps the byte address in bits 30:21, the length in bits 20:16, bit 15 and bit 1, and reads them back. Bits 31, 14:2 and 0 read as 0, so the read-enable bit clears itself.
- R4: A control write with bit 0 set while the controller is idle starts a burst and clears status bit 0 on the next cycle.
- R5: During a burst, `fuse_addr` carries the row index, which is byte address bits 9:5 zero-extended, and it does not change until the burst ends. Byte address bits 4:0 have no effect on which row is read.
- R6: `fuse_strobe` stays low for adjust+1 cycles after the start edge, then stays high for strobe+4 cycles.
- R7: Status bit 0 becomes 1 adjust+strobe+5 cycles after the start edge. It stays 1 until the next start.
- R8: Data word n holds `fuse_data` bits 32n+31:32n as sampled on the last strobe cycle. The data words keep their values until the next burst completes.
- R9: A control write that arrives during a burst is ignored completely: no new burst starts, the stored control fields are unchanged, and the current row is captured.
- R10: If configuration bit 31 is set when a burst completes, `irq` rises together with done. Writing 1 to status bit 0 clears `irq` and leaves done at 1. A new start also clears `irq`.
- R11: Status bit 1 always reads 0. A control write that sets only bit 1 or bit 15 starts no burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| fuse_addr | output | 9 | Row index to the fuse macro |
| fuse_strobe | output | 1 | Read strobe to the fuse macro |
| fuse_data | input | 256 | Row data from the fuse macro |
| irq | output | 1 | Completion interrupt |

## Verification
A wrong sequencer count does not show up as wrong data at once. It shows as a strobe that is too long or too short, or as done arriving a cycle early or late, and these appear within 36 cycles of the start. The bench fuse model drives valid data only while the strobe is high, so a capture on the wrong cycle loads zeros into the data words, and the next readback reveals it. A row index latched at the wrong time, or a start accepted while busy, loads the wrong row and shows up in the data words after the burst completes.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2
    } seq_state_t;

    localparam int REG_CTRL   = 0;
    localparam int REG_CFG    = 1;
    localparam int REG_STATUS = 2;
    localparam int REG_DATA0  = 3;

    localparam logic [31:0] CFG_KEEP_MASK = 32'h80FF_FFFF;
    localparam int          CFG_IEN_BIT   = 31;
    localparam int          CFG_ADJ_LSB   = 20;
    localparam int          CFG_STR_LSB   = 16;

    localparam int CTRL_ADDR_LSB = 21;
    localparam int CTRL_LEN_LSB  = 16;
    localparam int CTRL_PGM_BIT  = 15;
    localparam int CTRL_WEN_BIT  = 1;
    localparam int CTRL_REN_BIT  = 0;
endpackage

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
    import fuse_rd_pkg::*;
#(
    parameter int ADJ_W = 4,
    parameter int STR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ADJ_W-1:0] adj_cnt,
    input  logic [STR_W-1:0] str_cnt,
    output logic             busy,
    output logic             strobe,
    output logic             capture
);
    localparam int CNT_W = $clog2((1 << (ADJ_W > STR_W ? ADJ_W : STR_W)) + 4);

    seq_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [ADJ_W-1:0] adj_q;
    logic [STR_W-1:0] str_q;
    logic [CNT_W-1:0] strobe_last;

    assign strobe_last = CNT_W'(str_q) + CNT_W'(3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            adj_q   <= '0;
            str_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_SETUP;
                        cnt_q   <= '0;
                        adj_q   <= adj_cnt;
                        str_q   <= str_cnt;
                    end
                end
                ST_SETUP: begin
                    if (cnt_q == CNT_W'(adj_q)) begin
                        state_q <= ST_STROBE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_STROBE: begin
                    if (cnt_q == strobe_last) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy    = 1'b0;
        strobe  = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_SETUP:  busy = 1'b1;
            ST_STROBE: begin
                busy    = 1'b1;
                strobe  = 1'b1;
                capture = (cnt_q == strobe_last);
            end
            default: ;
        endcase
    end

    // R6
    setup_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |-> $past(busy));

    // R7
    capture_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !busy);

    // R9
    no_start_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !capture) |=> busy);
endmodule

// File: rtl/fuse_rd_regs.sv
module fuse_rd_regs
    import fuse_rd_pkg::*;
#(
    parameter int REG_AW  = 6,
    parameter int WORD_W  = 32,
    parameter int WORDS   = 8,
    parameter int BYTE_AW = 10,
    parameter int ROW_AW  = 9,
    parameter int ADJ_W   = 4,
    parameter int STR_W   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [REG_AW-1:0]       addr,
    input  logic [WORD_W-1:0]       wdata,
    output logic [WORD_W-1:0]       rdata,
    input  logic                    busy,
    input  logic                    capture,
    input  logic [WORDS*WORD_W-1:0] row_data,
    output logic                    start,
    output logic [ROW_AW-1:0]       row_idx,
    output logic [ADJ_W-1:0]        adj_cnt,
    output logic [STR_W-1:0]        str_cnt,
    output logic                    irq
);
    localparam int WIDX_W  = REG_AW - 2;
    localparam int WSEL_W  = $clog2(WORDS);
    localparam int OFF_W   = $clog2(WORDS * WORD_W / 8);
    localparam int RIDX_W  = BYTE_AW - OFF_W;

    logic [WIDX_W-1:0]  widx;
    logic [WIDX_W-1:0]  dofs;
    logic               ctrl_wr, status_wr, cfg_wr;
    logic [BYTE_AW-1:0] c_addr_q;
    logic [4:0]         c_len_q;
    logic               c_pgm_q, c_wen_q;
    logic [WORD_W-1:0]  cfg_q;
    logic               done_q, irq_q;
    logic [WORD_W-1:0]  data_q [WORDS];
    logic               unused_bits;

    assign widx      = addr[REG_AW-1:2];
    assign dofs      = widx - WIDX_W'(REG_DATA0);
    assign ctrl_wr   = wr_en && (widx == WIDX_W'(REG_CTRL)) && !busy;
    assign cfg_wr    = wr_en && (widx == WIDX_W'(REG_CFG));
    assign status_wr = wr_en && (widx == WIDX_W'(REG_STATUS));
    assign start     = ctrl_wr && wdata[CTRL_REN_BIT];
    assign row_idx   = ROW_AW'(c_addr_q[BYTE_AW-1:OFF_W]);
    assign adj_cnt   = cfg_q[CFG_ADJ_LSB +: ADJ_W];
    assign str_cnt   = cfg_q[CFG_STR_LSB +: STR_W];
    assign irq       = irq_q;
    assign unused_bits = ^{addr[1:0], RIDX_W'(0)};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_addr_q <= '0;
            c_len_q  <= '0;
            c_pgm_q  <= 1'b0;
            c_wen_q  <= 1'b0;
            cfg_q    <= '0;
        end else begin
            if (ctrl_wr) begin
                c_addr_q <= wdata[CTRL_ADDR_LSB +: BYTE_AW];
                c_len_q  <= wdata[CTRL_LEN_LSB +: 5];
                c_pgm_q  <= wdata[CTRL_PGM_BIT];
                c_wen_q  <= wdata[CTRL_WEN_BIT];
            end
            if (cfg_wr) cfg_q <= wdata & CFG_KEEP_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            irq_q  <= 1'b0;
        end else if (start) begin
            done_q <= 1'b0;
            irq_q  <= 1'b0;
        end else if (capture) begin
            done_q <= 1'b1;
            irq_q  <= cfg_q[CFG_IEN_BIT];
        end else if (status_wr && wdata[0]) begin
            irq_q  <= 1'b0;
        end
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       data_q[g] <= '0;
            else if (capture) data_q[g] <= row_data[g*WORD_W +: WORD_W];
        end

        // R8
        word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !capture |=> $stable(data_q[g]));
    end

    always_comb begin
        rdata = '0;
        if (widx == WIDX_W'(REG_CTRL)) begin
            rdata[CTRL_ADDR_LSB +: BYTE_AW] = c_addr_q;
            rdata[CTRL_LEN_LSB +: 5]        = c_len_q;
            rdata[CTRL_PGM_BIT]             = c_pgm_q;
            rdata[CTRL_WEN_BIT]             = c_wen_q;
        end else if (widx == WIDX_W'(REG_CFG)) begin
            rdata = cfg_q;
        end else if (widx == WIDX_W'(REG_STATUS)) begin
            rdata[0] = done_q;
        end else if (widx >= WIDX_W'(REG_DATA0) && widx < WIDX_W'(REG_DATA0 + WORDS)) begin
            rdata = data_q[dofs[WSEL_W-1:0]];
        end
    end

    // R4
    start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done_q);

    // R7
    capture_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> done_q);

    // R10
    irq_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> done_q);

    // R9
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx == WIDX_W'(REG_CTRL) && busy) |=> $stable(c_addr_q));
endmodule

// File: rtl/fuse_read_ctrl.sv
module fuse_read_ctrl #(
    parameter int REG_AW  = 6,
    parameter int WORD_W  = 32,
    parameter int WORDS   = 8,
    parameter int BYTE_AW = 10,
    parameter int ROW_AW  = 9,
    parameter int ADJ_W   = 4,
    parameter int STR_W   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [REG_AW-1:0]       reg_addr,
    input  logic [WORD_W-1:0]       reg_wdata,
    output logic [WORD_W-1:0]       reg_rdata,
    output logic [ROW_AW-1:0]       fuse_addr,
    output logic                    fuse_strobe,
    input  logic [WORDS*WORD_W-1:0] fuse_data,
    output logic                    irq
);
    logic             start, busy, capture;
    logic [ADJ_W-1:0] adj_cnt;
    logic [STR_W-1:0] str_cnt;

    fuse_rd_regs #(
        .REG_AW(REG_AW), .WORD_W(WORD_W), .WORDS(WORDS), .BYTE_AW(BYTE_AW),
        .ROW_AW(ROW_AW), .ADJ_W(ADJ_W), .STR_W(STR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .busy     (busy),
        .capture  (capture),
        .row_data (fuse_data),
        .start    (start),
        .row_idx  (fuse_addr),
        .adj_cnt  (adj_cnt),
        .str_cnt  (str_cnt),
        .irq      (irq)
    );

    fuse_rd_seq #(.ADJ_W(ADJ_W), .STR_W(STR_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .adj_cnt (adj_cnt),
        .str_cnt (str_cnt),
        .busy    (busy),
        .strobe  (fuse_strobe),
        .capture (capture)
    );

    // R5
    row_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(fuse_addr));

    // R6
    strobe_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_strobe |-> busy);
endmodule

// File: tb/test_fuse_read_ctrl.sv
module test_fuse_read_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [5:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [8:0]   fuse_addr;
    logic         fuse_strobe;
    logic [255:0] fuse_data;
    logic         irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fuse_read_ctrl i_fuse_read_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fuse_addr(fuse_addr),
        .fuse_strobe(fuse_strobe), .fuse_data(fuse_data), .irq(irq)
    );

    function automatic logic [31:0] fuse_word(input int row, input int n);
        return ((row + 32'd1) * 32'h9E37_79B1) ^ (n * 32'h0101_0101) ^ 32'h5A00_00C3;
    endfunction

    // fuse model: data valid only while the strobe is high
    always_comb begin
        fuse_data = '0;
        if (fuse_strobe)
            for (int n = 0; n < 8; n++) fuse_data[n*32 +: 32] = fuse_word(int'(fuse_addr), n);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 6'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input int a, output logic [31:0] v);
        reg_addr = 6'(a);
        #1;
        v = reg_rdata;
    endtask

    task automatic check_row(input string req, input int row);
        logic [31:0] v;
        for (int n = 0; n < 8; n++) begin
            bus_read(12 + 4*n, v);
            check(req, v, fuse_word(row, n));
        end
    endtask

    task automatic wait_done(output int at);
        logic [31:0] v;
        at = -1;
        for (int n = 0; n < 64; n++) begin
            bus_read(8, v);
            if (v[0]) begin at = n; break; end
            @(negedge clk);
        end
    endtask

    task automatic burst(input int baddr, input int adj, input int st, input bit ien);
        logic [31:0] v;
        int setup_n, strobe_n, done_at;
        bus_write(4, (32'(ien) << 31) | (32'(adj) << 20) | (32'(st) << 16));
        bus_write(0, (32'(baddr) << 21) | (32'd31 << 16) | 32'd1);
        setup_n = 0; strobe_n = 0; done_at = -1;
        #1;
        check("R5 row index", 32'(fuse_addr), 32'(baddr >> 5));
        bus_read(8, v);
        check("R4 done cleared", {31'd0, v[0]}, 32'd0);
        for (int n = 0; n < 64; n++) begin
            bus_read(8, v);
            if (v[0]) begin done_at = n; break; end
            if (fuse_strobe) strobe_n++;
            else if (strobe_n == 0) setup_n++;
            @(negedge clk);
        end
        check("R6 setup cycles", 32'(setup_n), 32'(adj + 1));
        check("R6 strobe cycles", 32'(strobe_n), 32'(st + 4));
        check("R7 done cycle", 32'(done_at), 32'(adj + st + 5));
        check("R10 irq", {31'd0, irq}, {31'd0, ien});
        check_row("R8 data word", baddr >> 5);
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int at;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        for (int a = 0; a < 11; a++) begin
            bus_read(4*a, v);
            check("R1 reset register", v, 32'd0);
        end
        check("R1 reset irq", {31'd0, irq}, 32'd0);
        check("R1 reset strobe", {31'd0, fuse_strobe}, 32'd0);

        // R2 configuration field retention
        bus_write(4, 32'hFFFF_FFFF);
        bus_read(4, v);
        check("R2 config mask", v, 32'h80FF_FFFF);

        // R3 control readback, read-enable self clear
        bus_write(0, 32'hFFFF_FFFE);
        bus_read(0, v);
        check("R3 control readback", v, 32'h7FFF_8002);
        bus_read(8, v);
        check("R11 no start from bits 1/15", v, 32'd0);
        check("R11 strobe idle", {31'd0, fuse_strobe}, 32'd0);

        // Directed: minimum and maximum timing, address offset ignored (R5)
        burst(0, 0, 0, 1'b0);
        burst(31*32 + 13, 15, 15, 1'b1);

        // R10 write-one clears irq, done stays
        bus_write(8, 32'd1);
        check("R10 irq cleared", {31'd0, irq}, 32'd0);
        bus_read(8, v);
        check("R10 done kept", v, 32'd1);

        // R11 write/program bits start nothing; done remains sticky
        bus_write(0, 32'h0000_8002);
        repeat (3) @(negedge clk);
        bus_read(8, v);
        check("R11 status bits", v, 32'd1);
        check_row("R8 data held", 31);

        // R9 control write during a burst is ignored
        bus_write(4, (32'd15 << 20) | (32'd15 << 16));
        bus_write(0, (32'd5*32 << 21) | (32'd31 << 16) | 32'd1);
        bus_write(0, (32'd9*32 << 21) | (32'd31 << 16) | 32'd1);
        wait_done(at);
        check("R9 burst completes", {31'd0, at >= 0}, 32'd1);
        bus_read(0, v);
        check("R9 control unchanged", v, (32'd5*32 << 21) | (32'd31 << 16));
        check_row("R9 original row captured", 5);

        // Random bursts
        for (int k = 0; k < 16; k++) begin
            burst(int'($urandom_range(0, 1023)), int'($urandom_range(0, 15)),
                  int'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
        end

        // R10 start clears a pending irq
        burst(64, 2, 3, 1'b1);
        bus_write(0, (32'd96 << 21) | 32'd1);
        check("R10 start clears irq", {31'd0, irq}, 32'd0);
        wait_done(at);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule